// File: doc/BRIEF.md
# Timed Register-Write Stream Player

This block replays a recorded sequence of register writes into a dedicated sound generator, with the timing of each write preserved. The sequence lives in a byte-wide on-chip memory that the player reads through a simple address/data port with one cycle of read latency. A fixed 16-byte preamble at the start of the memory is passed over. After it come the commands: a register write (register number plus one data byte), a delay measured in ticks of a 1 MHz timebase, and an end marker.

The tick timebase comes from a prescaler that divides the system clock by a parameter. It runs without interruption for as long as playback is active, so a run of delays never loses or gains a fraction of a tick. Writes with no delay between them go out on the register bus as quickly as the memory can deliver their bytes. Playback is started and aborted by pulses. A loop flag picks between halting at the end marker and restarting from the first command.

Top module: `regstream_player`

## Requirements
- R1: During and directly after reset, `busy_o`, `done_o` and `reg_we_o` are low.
- R2: Decoding starts at memory offset 16. The 16 bytes before that offset are never decoded, whatever values they hold. `busy_o` rises in the cycle after `start_i` is sampled, and the first command is decoded in the second busy cycle.
- R3: An opcode in the range 0x00–0x1F, followed by one data byte, produces exactly one `reg_we_o` pulse. That pulse carries `reg_addr_o` equal to the opcode's low five bits and `reg_data_o` equal to the data byte, and it appears two cycles after the cycle in which the opcode is decoded.
- R4: Consecutive write commands produce one strobe each, two cycles apart, and strobes are never high in two successive cycles.
- R5: Opcode 0x80 is followed by a 16-bit tick count, low byte first. A nonzero count N holds decoding until the N-th tick that falls at or after the third cycle after the opcode. The next command is decoded in the cycle after that tick.
- R6: A tick occurs every CLK_DIV cycles while busy, first in the CLK_DIV-th busy cycle. The tick phase continues across loop restarts.
- R7: A tick count of zero adds no delay: the next command is decoded three cycles after the 0x80 opcode.
- R8: Opcode 0xFF ends the stream. With `loop_i` low, `busy_o` falls and `done_o` rises in the next cycle, and `done_o` stays high until a start or a stop. With `loop_i` high, `done_o` pulses for one cycle and decoding resumes at offset 16 two cycles after the marker.
- R9: Every other opcode value (0x20–0x7F and 0x81–0xFE) is a one-byte no-op that produces no strobe, and the next byte is decoded in the following cycle.
- R10: Once `stop_i` has been sampled, no strobe appears until the next start, and `busy_o` and `done_o` are low from the next cycle. When stop and start are sampled together, stop wins.
- R11: `start_i` has no effect while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin playback from offset 16 when idle |
| stop_i | input | 1 | Abort playback and clear done |
| loop_i | input | 1 | Restart at the first command after the end marker |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | End marker reached (level when not looping, pulse when looping) |
| mem_addr_o | output | ADDR_W | Stream memory read address |
| mem_data_i | input | 8 | Stream memory data, valid one cycle after its address |
| reg_addr_o | output | 5 | Sound generator register number |
| reg_data_o | output | 8 | Sound generator register value |
| reg_we_o | output | 1 | One-cycle register write strobe |

## Verification
Two things can happen in the same cycle here. One is a stop request. The other is the decode of a write's data byte, which would put out a strobe one cycle later. The bench plays a looping stream, looks up in its own schedule the cycle just before a due strobe, and raises stop together with start in exactly that cycle. It then expects no strobe in that cycle or afterwards, and expects busy and done to fall at once. A cycle-by-cycle model built from the requirements judges every bus cycle, including delays that end on tick boundaries and the tick phase carried over a loop restart.

// File: rtl/regstream_pkg.sv
package regstream_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_OPC,
        ST_WDATA,
        ST_WLO,
        ST_WHI,
        ST_WAIT
    } play_state_e;

    localparam logic [7:0] OPC_WRITE_LIMIT = 8'h20;
    localparam logic [7:0] OPC_DELAY       = 8'h80;
    localparam logic [7:0] OPC_END         = 8'hFF;
    localparam int         REG_AW          = 5;

endpackage

// File: rtl/regstream_tick_gen.sv
module regstream_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/regstream_wait_timer.sv
module regstream_wait_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          expire_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    assign expire_o = tick_i && (cnt_q == CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/regstream_player.sv
module regstream_player #(
    parameter int ADDR_W    = 12,
    parameter int CLK_DIV   = 50,
    parameter int HDR_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              loop_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic [4:0]        reg_addr_o,
    output logic [7:0]        reg_data_o,
    output logic              reg_we_o
);
    import regstream_pkg::*;

    localparam logic [ADDR_W-1:0] FIRST_CMD = ADDR_W'(HDR_BYTES);
    localparam int                CNT_W     = 16;

    typedef struct packed {
        play_state_e       state;
        logic [ADDR_W-1:0] ptr;
        logic [REG_AW-1:0] regsel;
        logic [7:0]        lo;
        logic              we;
        logic [REG_AW-1:0] waddr;
        logic [7:0]        wdata;
        logic              done;
    } play_regs_t;

    play_regs_t d, q;

    logic             tick_w;
    logic             expire_w;
    logic             load_w;
    logic [CNT_W-1:0] load_val_w;

    assign busy_o     = (q.state != ST_IDLE);
    assign done_o     = q.done;
    assign mem_addr_o = q.ptr;
    assign reg_addr_o = q.waddr;
    assign reg_data_o = q.wdata;
    assign reg_we_o   = q.we;
    assign load_val_w = {mem_data_i, q.lo};

    regstream_tick_gen #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .tick_o (tick_w)
    );

    regstream_wait_timer #(.CW(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load_w),
        .load_val_i (load_val_w),
        .tick_i     (tick_w),
        .expire_o   (expire_w)
    );

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        load_w = 1'b0;
        if (q.state != ST_IDLE) d.done = 1'b0;

        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state = ST_PRIME;
                    d.ptr   = FIRST_CMD;
                    d.done  = 1'b0;
                end
            end
            ST_PRIME: begin
                // first address is on the bus; data lands next cycle
                d.ptr   = q.ptr + 1'b1;
                d.state = ST_OPC;
            end
            ST_OPC: begin
                d.ptr = q.ptr + 1'b1;
                if (mem_data_i < OPC_WRITE_LIMIT) begin
                    d.regsel = mem_data_i[REG_AW-1:0];
                    d.state  = ST_WDATA;
                end else if (mem_data_i == OPC_DELAY) begin
                    d.state = ST_WLO;
                end else if (mem_data_i == OPC_END) begin
                    d.done = 1'b1;
                    if (loop_i) begin
                        d.ptr   = FIRST_CMD;
                        d.state = ST_PRIME;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end else begin
                    d.state = ST_OPC;
                end
            end
            ST_WDATA: begin
                d.we    = 1'b1;
                d.waddr = q.regsel;
                d.wdata = mem_data_i;
                d.ptr   = q.ptr + 1'b1;
                d.state = ST_OPC;
            end
            ST_WLO: begin
                d.lo    = mem_data_i;
                d.ptr   = q.ptr + 1'b1;
                d.state = ST_WHI;
            end
            ST_WHI: begin
                if (load_val_w == '0) begin
                    d.ptr   = q.ptr + 1'b1;
                    d.state = ST_OPC;
                end else begin
                    // hold the next opcode address while the delay runs
                    load_w  = 1'b1;
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (expire_w) begin
                    d.ptr   = q.ptr + 1'b1;
                    d.state = ST_OPC;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (stop_i) begin
            d.state = ST_IDLE;
            d.we    = 1'b0;
            d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= ST_IDLE;
            q.ptr    <= '0;
            q.regsel <= '0;
            q.lo     <= '0;
            q.we     <= 1'b0;
            q.waddr  <= '0;
            q.wdata  <= '0;
            q.done   <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/regstream_player_chk.sv
module regstream_player_chk #(
    parameter int DIV = 50
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic stop_i,
    input logic busy_o,
    input logic reg_we_o,
    input logic tick_i
);
    int gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !busy_o || tick_i) gap_q <= 0;
        else                             gap_q <= gap_q + 1;
    end

    // R3
    strobe_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> busy_o);

    // R4
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R10
    stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (!busy_o && !reg_we_o));

    // R2
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stop_i && !busy_o) |=> busy_o);

    // R6
    tick_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (tick_i == (gap_q == DIV - 1)));
endmodule

bind regstream_player regstream_player_chk #(.DIV(CLK_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .busy_o   (busy_o),
    .reg_we_o (reg_we_o),
    .tick_i   (tick_w)
);

// File: tb/regstream_player_test.sv
module regstream_player_test;
    localparam int AW  = 8;
    localparam int DIV = 5;
    localparam int HDR = 16;
    localparam int BIG = 1 << 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, stop_i = 1'b0, loop_i = 1'b0;
    logic          busy_o, done_o, reg_we_o;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_data_i;
    logic [4:0]    reg_addr_o;
    logic [7:0]    reg_data_o;

    logic [7:0] mem [0:255];
    int cyc = 0;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) mem_data_i <= mem[mem_addr_o];

    regstream_player #(.ADDR_W(AW), .CLK_DIV(DIV), .HDR_BYTES(HDR)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .loop_i(loop_i), .busy_o(busy_o), .done_o(done_o),
        .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o), .reg_we_o(reg_we_o)
    );

    // reference model state
    int t0 = 0, busy_end = 0, done_from = BIG, stop_at = BIG;
    logic [12:0] exp_wr [int];
    bit exp_pulse [int];
    string tag = "R1";

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic step();
        bit eb, ed, ew;
        @(negedge clk);
        if (rst_n) begin
            eb = (cyc >= t0) && (cyc < busy_end) && (cyc <= stop_at);
            ed = (cyc >= t0) && (exp_pulse.exists(cyc) || cyc >= done_from) && (cyc <= stop_at);
            ew = exp_wr.exists(cyc) && (cyc <= stop_at);
            chk(busy_o == eb, tag, "busy", int'(busy_o), int'(eb));
            chk(done_o == ed, tag, "done", int'(done_o), int'(ed));
            chk(reg_we_o == ew, tag, "strobe", int'(reg_we_o), int'(ew));
            if (ew) chk({reg_addr_o, reg_data_o} == exp_wr[cyc], tag, "addr/data",
                        int'({reg_addr_o, reg_data_o}), int'(exp_wr[cyc]));
        end
    endtask

    // Behavioural interpretation of the stream from the requirements.
    task automatic build(int start_cyc, bit lp, int horizon);
        int t, p, n, c;
        exp_wr.delete();
        exp_pulse.delete();
        t0 = start_cyc; stop_at = BIG; done_from = BIG; busy_end = BIG;
        t = t0 + 1; p = HDR;
        while (t < horizon) begin
            if (mem[p] < 8'h20) begin
                exp_wr[t + 2] = {mem[p][4:0], mem[p + 1]};
                p += 2; t += 2;
            end else if (mem[p] == 8'h80) begin
                n = int'(mem[p + 1]) | (int'(mem[p + 2]) << 8);
                p += 3; t += 3;
                if (n > 0) begin
                    c = t;
                    while (((c - t0) % DIV) != DIV - 1) c++;
                    c += (n - 1) * DIV;
                    t = c + 1;
                end
            end else if (mem[p] == 8'hFF) begin
                if (lp) begin
                    exp_pulse[t + 1] = 1;
                    p = HDR; t += 2;
                end else begin
                    done_from = t + 1; busy_end = t + 1;
                    break;
                end
            end else begin
                p += 1; t += 1;
            end
        end
    endtask

    task automatic load_stream(input logic [7:0] s []);
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        for (int i = 0; i < HDR; i++) mem[i] = (i % 2 == 0) ? 8'h80 : 8'h01;
        foreach (s[i]) mem[HDR + i] = s[i];
    endtask

    task automatic kick(bit lp, int horizon);
        loop_i = lp;
        start_i = 1'b1;
        build(cyc + 1, lp, horizon);
        step();
        start_i = 1'b0;
    endtask

    task automatic run_to_idle();
        while (cyc < busy_end + 4) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int w;
        for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            chk(!busy_o && !done_o && !reg_we_o, "R1", "reset outputs",
                int'({busy_o, done_o, reg_we_o}), 0);
        end
        rst_n = 1'b1;
        step();
        chk(!busy_o && !done_o && !reg_we_o, "R1", "after reset",
            int'({busy_o, done_o, reg_we_o}), 0);

        // R2 R3 R4 R8: back-to-back writes behind a hostile header, no loop
        tag = "R2/R3/R4/R8";
        load_stream('{8'h01, 8'hAA, 8'h02, 8'h55, 8'h1F, 8'h3C, 8'h00, 8'h00, 8'hFF});
        kick(1'b0, BIG);
        run_to_idle();
        chk(done_o == 1'b1, "R8", "done held", int'(done_o), 1);

        // R5 R6 R7 R11: zero and nonzero delays, start pulsed mid-delay
        tag = "R5/R6/R7/R11";
        load_stream('{8'h04, 8'h11, 8'h80, 8'h00, 8'h00, 8'h05, 8'h22,
                      8'h80, 8'h01, 8'h00, 8'h06, 8'h33, 8'h80, 8'h07, 8'h00,
                      8'h07, 8'h44, 8'h80, 8'h2C, 8'h01, 8'h08, 8'h55, 8'hFF});
        kick(1'b0, BIG);
        repeat (200) step();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R11", "busy after ignored start", int'(busy_o), 1);
        run_to_idle();

        // R9: unknown opcodes are single-byte no-ops
        tag = "R9";
        load_stream('{8'h0A, 8'h01, 8'h20, 8'h7F, 8'h81, 8'hFE, 8'h0B, 8'h02, 8'hFF});
        kick(1'b0, BIG);
        run_to_idle();

        // R8 R6 R10: looping stream, stop and start raised in a write's data cycle
        tag = "R8/R6/R10";
        load_stream('{8'h03, 8'h99, 8'h80, 8'h04, 8'h00, 8'h12, 8'h77, 8'hFF});
        kick(1'b1, cyc + 400);
        repeat (120) step();
        w = 0;
        foreach (exp_wr[k]) if (k > cyc + 3 && (w == 0 || k < w)) w = k;
        while (cyc < w - 1) step();
        stop_i = 1'b1; start_i = 1'b1;
        stop_at = cyc;
        step();
        stop_i = 1'b0; start_i = 1'b0;
        repeat (20) step();
        chk(!busy_o && !done_o, "R10", "halted after stop",
            int'({busy_o, done_o}), 0);

        // R10: stop while idle clears a held done
        tag = "R10";
        load_stream('{8'h01, 8'h0F, 8'hFF});
        kick(1'b0, BIG);
        run_to_idle();
        chk(done_o == 1'b1, "R8", "done before stop", int'(done_o), 1);
        stop_i = 1'b1;
        stop_at = cyc;
        step();
        stop_i = 1'b0;
        repeat (4) step();
        chk(done_o == 1'b0, "R10", "done cleared by stop", int'(done_o), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule